// File: doc/BRIEF.md
# Remote Terminal Command Address Generator

This block sits in a serial-bus remote terminal, between the command decoder and the parallel memory interface of the subsystem. A decoded 16-bit command word arrives with a one-cycle valid strobe. The block checks its terminal-address field. An accepted command is held pending until the bus grant strobe. At the grant, the broadcast flag, transmit/receive bit, subaddress and count/mode field are copied into the field registers that drive the 14-bit subsystem address.

After the grant, the command word is transferred with the command/data line low. The block then raises `in_cmd` for the data phase. During that phase the five count lines carry a live word index, which advances once per data-word handshake or timeout. For a mode command, the lines carry the mode code instead, and the single data word falls 32 word locations above the command-word location. In byte mode, the lowest address line selects the byte, with the upper byte first.

Command word layout: bits 15..11 terminal address, bit 10 transmit/receive (1 = transmit), bits 9..5 subaddress, bits 4..0 word count or mode code. Address layout: bit 13 broadcast, bit 12 transmit/receive, bits 11..7 subaddress (bit 11 is the MSB), bit 6 command(0)/data(1), bits 5..1 count lines (bit 5 is the MSB), bit 0 byte select.

Top module: `rt_cmd_addr_gen`

## Requirements
- R1: A command is taken only when the block is idle and its address field is either 11111 (broadcast) or equal to `rt_addr`, with `{rt_addr, rt_par}` having odd parity. A command that is not taken leaves `sub_addr` and `in_cmd` unchanged.
- R2: The field registers load on the bus grant, never earlier. The loaded values drive bit 13 (1 = broadcast), bit 12 (command bit 10) and bits 11..7 (command bits 9..5). These bits hold steady while `in_cmd` is high.
- R3: Bit 6 is 0 only while the command word is being transferred, and 1 at every other time, including every data-word transfer.
- R4: During the command-word transfer, bits 5..1 are 00000 for a non-mode command and the mode code for a mode command. A mode command is one whose subaddress is 00000 or 11111.
- R5: For a non-mode command, bits 5..1 read 0 when `in_cmd` rises. They then advance by one after each data-word handshake, and by one after each `xfer_timeout`.
- R6: A non-mode command runs for as many data words as its count field states, with 00000 meaning 32. `in_cmd` then falls, and bits 5..1 return to the latched count field.
- R7: A mode command whose code has bit 4 set has exactly one data word. That word is addressed with bit 6 at 1 and bits 5..1 at the mode code, which is 32 word locations above the command word. A mode code with bit 4 clear has no data phase.
- R8: With `byte_mode` high, every word takes two `xfer_done` strobes. Bit 0 is 1 for the first (upper byte) and 0 for the second. With `byte_mode` low, bit 0 is always 1.
- R9: When `xfer_done` and `xfer_timeout` arrive in the same cycle, the word index advances exactly once, and bit 0 returns to 1.
- R10: A command valid strobe or grant strobe during an active command has no effect on `sub_addr`.
- R11: While `rst_n` is low, `sub_addr` is 14'h0041 and `in_cmd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, held for at least 2 cycles |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_word` holds a decoded command |
| cmd_word | input | 16 | Received command word |
| rt_addr | input | 5 | This terminal's address |
| rt_par | input | 1 | Parity bit for `rt_addr` (odd parity over all six bits) |
| byte_mode | input | 1 | 1 = 8-bit subsystem bus, 0 = 16-bit |
| bus_grant | input | 1 | One-cycle strobe: subsystem bus granted |
| xfer_done | input | 1 | One-cycle strobe: one bus transfer completed |
| xfer_timeout | input | 1 | One-cycle strobe: handshake timed out, current word abandoned |
| in_cmd | output | 1 | High during the data-word phase of a command |
| sub_addr | output | 14 | Subsystem address bus |

## Verification
Two events can land in the same cycle: a transfer-done handshake and a handshake timeout. The bench drives both strobes together in 16-bit mode and again on the upper byte in byte mode. In each case it expects the word index to step by exactly one and the byte select to return to the upper byte. It also raises a new command strobe and a grant while a data phase is running. It then judges that the field bits and the word index on the address bus are unchanged.

// File: rtl/rt_addr_pkg.sv
package rt_addr_pkg;
  localparam int FLD_W   = 5;
  localparam int CMD_W   = 16;
  localparam int BODY_W  = 2 * FLD_W + 1;
  localparam int CNT_W   = FLD_W + 1;
  localparam int SADDR_W = 2 * FLD_W + 4;
  localparam logic [FLD_W-1:0] FLD_ONES = '1;

  typedef enum logic [1:0] {PH_IDLE, PH_PEND, PH_CMD, PH_DATA} phase_t;

  typedef struct packed {
    logic             bcast;
    logic             tx;
    logic [FLD_W-1:0] sa;
    logic [FLD_W-1:0] cnt_fld;
  } cmd_lat_t;

  function automatic logic is_mode_sa(input logic [FLD_W-1:0] sa);
    return (sa == '0) || (sa == FLD_ONES);
  endfunction

  // number of data words a latched command carries
  function automatic logic [CNT_W-1:0] words_due(input logic mode,
                                                 input logic [FLD_W-1:0] fld);
    if (mode) return fld[FLD_W-1] ? CNT_W'(1) : '0;
    return (fld == '0) ? CNT_W'(1 << FLD_W) : {1'b0, fld};
  endfunction

  function automatic logic odd_par(input logic [FLD_W-1:0] a, input logic p);
    return ^{a, p};
  endfunction
endpackage

// File: rtl/rt_addr_match.sv
module rt_addr_match
  import rt_addr_pkg::*;
#(
  parameter int FW = FLD_W
) (
  input  logic [FW-1:0] rt_fld,
  input  logic [FW-1:0] own_addr,
  input  logic          own_par,
  output logic          hit,
  output logic          bcast
);
  assign bcast = &rt_fld;
  assign hit   = bcast | ((rt_fld == own_addr) & (^{own_addr, own_par}));
endmodule

// File: rtl/rt_word_counter.sv
module rt_word_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + 1'b1;
  end
endmodule

// File: rtl/rt_addr_mux.sv
module rt_addr_mux
  import rt_addr_pkg::*;
(
  input  cmd_lat_t           lat,
  input  logic               cmd_phase,
  input  logic               data_phase,
  input  logic               mode,
  input  logic               upper,
  input  logic               byte_mode,
  input  logic [FLD_W-1:0]   cnt_lo,
  output logic [SADDR_W-1:0] addr
);
  logic [FLD_W-1:0] low;
  logic             bsel;

  always_comb begin
    if (cmd_phase)       low = mode ? lat.cnt_fld : '0;
    else if (data_phase) low = mode ? lat.cnt_fld : cnt_lo;
    else                 low = lat.cnt_fld;
  end

  assign bsel = byte_mode ? upper : 1'b1;
  assign addr = {lat.bcast, lat.tx, lat.sa, ~cmd_phase, low, bsel};
endmodule

// File: rtl/rt_cmd_addr_gen.sv
module rt_cmd_addr_gen
  import rt_addr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic [FLD_W-1:0]   rt_addr,
  input  logic               rt_par,
  input  logic               byte_mode,
  input  logic               bus_grant,
  input  logic               xfer_done,
  input  logic               xfer_timeout,
  output logic               in_cmd,
  output logic [SADDR_W-1:0] sub_addr
);
  phase_t            st;
  cmd_lat_t          lat;
  logic              pend_bc;
  logic [BODY_W-1:0] pend_body;
  logic              upper;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  total;
  logic              hit, bc, accept;
  logic              cmd_phase, data_phase, mode_lat;
  logic              word_done, half_done, cmd_end, word_step, last_word;

  rt_addr_match #(.FW(FLD_W)) u_match (
    .rt_fld   (cmd_word[CMD_W-1 -: FLD_W]),
    .own_addr (rt_addr),
    .own_par  (rt_par),
    .hit      (hit),
    .bcast    (bc)
  );

  assign accept     = cmd_valid & hit & (st == PH_IDLE);
  assign cmd_phase  = (st == PH_CMD);
  assign data_phase = (st == PH_DATA);
  assign in_cmd     = data_phase;
  assign mode_lat   = is_mode_sa(lat.sa);
  assign total      = words_due(mode_lat, lat.cnt_fld);

  // a word ends on its last byte, or at once on a timeout
  assign word_done  = xfer_timeout | (xfer_done & (~byte_mode | ~upper));
  assign half_done  = xfer_done & byte_mode & upper & ~xfer_timeout;
  assign cmd_end    = cmd_phase & word_done;
  assign word_step  = data_phase & word_done;
  assign last_word  = word_step & (CNT_W'(cnt + 1'b1) == total);

  rt_word_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_end),
    .step  (word_step),
    .count (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      lat       <= '0;
      pend_bc   <= 1'b0;
      pend_body <= '0;
      upper     <= 1'b1;
    end else begin
      case (st)
        PH_IDLE: if (accept) begin
          pend_bc   <= bc;
          pend_body <= cmd_word[BODY_W-1:0];
          st        <= PH_PEND;
        end
        PH_PEND: if (bus_grant) begin
          lat   <= {pend_bc, pend_body};
          upper <= 1'b1;
          st    <= PH_CMD;
        end
        PH_CMD: begin
          if (word_done) begin
            upper <= 1'b1;
            st    <= (total == '0) ? PH_IDLE : PH_DATA;
          end else if (half_done) begin
            upper <= 1'b0;
          end
        end
        PH_DATA: begin
          if (word_done) begin
            upper <= 1'b1;
            if (last_word) st <= PH_IDLE;
          end else if (half_done) begin
            upper <= 1'b0;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  rt_addr_mux u_mux (
    .lat        (lat),
    .cmd_phase  (cmd_phase),
    .data_phase (data_phase),
    .mode       (mode_lat),
    .upper      (upper),
    .byte_mode  (byte_mode),
    .cnt_lo     (cnt[FLD_W-1:0]),
    .addr       (sub_addr)
  );
endmodule

// File: rtl/rt_cmd_addr_chk.sv
module rt_cmd_addr_chk
  import rt_addr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [SADDR_W-1:0] sub_addr,
  input logic               in_cmd,
  input logic               byte_mode,
  input logic               cmd_phase,
  input logic               word_step,
  input logic               mode_lat
);
  // R3
  a06_low_only_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_addr[6] |-> cmd_phase);

  // R3
  a06_high_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmd |-> sub_addr[6]);

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_cmd) && !mode_lat) |-> (sub_addr[5:1] == 5'd0));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && $past(word_step) && !mode_lat)
      |-> (sub_addr[5:1] == $past(sub_addr[5:1]) + 5'd1));

  // R2
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && $past(in_cmd)) |-> $stable(sub_addr[13:7]));

  // R8
  word_mode_a00_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode |-> sub_addr[0]);
endmodule

bind rt_cmd_addr_gen rt_cmd_addr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sub_addr  (sub_addr),
  .in_cmd    (in_cmd),
  .byte_mode (byte_mode),
  .cmd_phase (cmd_phase),
  .word_step (word_step),
  .mode_lat  (mode_lat)
);

// File: tb/rt_cmd_addr_gen_test.sv
`timescale 1ns/1ps
module rt_cmd_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [4:0]  rt_addr = '0;
  logic        rt_par = 1'b0;
  logic        byte_mode = 1'b0;
  logic        bus_grant = 1'b0;
  logic        xfer_done = 1'b0;
  logic        xfer_timeout = 1'b0;
  logic        in_cmd;
  logic [13:0] sub_addr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  rt_cmd_addr_gen uut (.*);

  // {command word, terminal address, parity bit, byte mode}
  localparam logic [22:0] VEC [8] = '{
    {5'd3,  1'b1, 5'd4,  5'd3,  5'd3, 1'b1, 1'b0},
    {5'd31, 1'b0, 5'd2,  5'd0,  5'd3, 1'b1, 1'b0},
    {5'd3,  1'b0, 5'd6,  5'd1,  5'd3, 1'b0, 1'b0},
    {5'd3,  1'b1, 5'd0,  5'd17, 5'd3, 1'b1, 1'b1},
    {5'd3,  1'b0, 5'd31, 5'd2,  5'd3, 1'b1, 1'b0},
    {5'd5,  1'b1, 5'd7,  5'd4,  5'd3, 1'b1, 1'b0},
    {5'd6,  1'b0, 5'd9,  5'd2,  5'd6, 1'b1, 1'b1},
    {5'd31, 1'b1, 5'd31, 5'd31, 5'd6, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic strobe(input logic v, input logic g, input logic d, input logic t);
    @(negedge clk);
    cmd_valid = v; bus_grant = g; xfer_done = d; xfer_timeout = t;
    @(negedge clk);
    cmd_valid = 0; bus_grant = 0; xfer_done = 0; xfer_timeout = 0;
  endtask

  task automatic issue(input logic [15:0] w, input logic [4:0] a, input logic p, input logic bm);
    rt_addr = a; rt_par = p; byte_mode = bm; cmd_word = w;
    strobe(1, 0, 0, 0);
    strobe(0, 1, 0, 0);
  endtask

  task automatic move_word(input logic bm, input string req);
    if (bm) begin
      check(req, 14'(sub_addr[0]), 14'd1);
      strobe(0, 0, 1, 0);
      check(req, 14'(sub_addr[0]), 14'd0);
    end
    strobe(0, 0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11", sub_addr, 14'h0041);
    check("R11", 14'(in_cmd), 14'd0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      logic [15:0] w;
      logic [4:0]  a, f, sa;
      logic        p, bm, bc, acc, md, tr;
      logic [13:0] prev;
      int          total;
      {w, a, p, bm} = VEC[k];
      bc  = (w[15:11] == 5'd31);
      acc = bc || ((w[15:11] == a) && (^{a, p}));
      tr = w[10]; sa = w[9:5]; f = w[4:0];
      md = (sa == 5'd0) || (sa == 5'd31);
      total = md ? (f[4] ? 1 : 0) : ((f == 0) ? 32 : int'(f));
      prev = sub_addr;
      issue(w, a, p, bm);
      if (!acc) begin
        check("R1", sub_addr, prev);
        check("R1", 14'(in_cmd), 14'd0);
      end else begin
        check("R2/R3/R4", sub_addr, {bc, tr, sa, 1'b0, (md ? f : 5'd0), 1'b1});
        move_word(bm, "R8");
        for (int i = 0; i < total; i++) begin
          check("R5", 14'(in_cmd), 14'd1);
          check(md ? "R7" : "R5", sub_addr[6:1], {1'b1, (md ? f : 5'(i))});
          move_word(bm, "R8");
        end
        check("R6", 14'(in_cmd), 14'd0);
        check("R6", sub_addr, {bc, tr, sa, 1'b1, f, 1'b1});
      end
    end

    // R9 coincident strobes, 16-bit mode; then timeout alone (R5)
    issue({5'd3, 1'b0, 5'd5, 5'd3}, 5'd3, 1'b1, 1'b0);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 1, 1);
    check("R9", sub_addr[5:0], {5'd1, 1'b1});
    strobe(0, 0, 0, 1);
    check("R5", sub_addr[5:0], {5'd2, 1'b1});
    // R10 new command and grant while busy
    cmd_word = {5'd31, 1'b1, 5'd12, 5'd9};
    strobe(1, 1, 0, 0);
    check("R10", sub_addr, {1'b0, 1'b0, 5'd5, 1'b1, 5'd2, 1'b1});
    strobe(0, 0, 1, 0);
    check("R6", 14'(in_cmd), 14'd0);

    // R9 coincident strobes on the upper byte in byte mode
    issue({5'd3, 1'b1, 5'd8, 5'd2}, 5'd3, 1'b1, 1'b1);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 1, 1);
    check("R9", sub_addr[5:0], {5'd1, 1'b1});
    check("R9", 14'(in_cmd), 14'd1);

    // R11 reset in mid command
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", sub_addr, 14'h0041);
    check("R11", 14'(in_cmd), 14'd0);
    rst_n = 1'b1;
    @(negedge clk);
    report();
    $finish;
  end
endmodule